// File: doc/BRIEF.md
# I2C Master FIFO and Interrupt Register Block

This block is the register-facing half of an I2C master. A 32-bit register port reaches six word locations. They are a FIFO control word, a FIFO status word, an interrupt enable word, a sticky interrupt status word, a transmit data port and a receive data port. Behind the ports sit two word-wide FIFOs, each eight entries of four bytes. Software loads outgoing words into the transmit FIFO, and the bit engine takes them out through a pop strobe. The engine pushes received words into the receive FIFO, and software reads them back through the receive data port.

The engine reports what happens on the wire with single-cycle pulses: packet done, all packets done, missing acknowledge and lost arbitration. It can also signal transmit overflow and receive underflow by pulse. The block latches these pulses as sticky event bits, which software clears by writing ones. Two further status bits are live data-request levels. Each one compares a FIFO level against a trigger field that software programs. The status bits are gated by the enable word and combined into one registered interrupt line.

Register word index (addr_i): 0 FIFO control, 1 FIFO status, 2 interrupt enable, 3 interrupt status, 4 transmit data (write), 5 receive data (read). A read returns its data on rdata_o one clock after the request cycle.

Top module: `i2c_fifo_intc`

## Requirements
- R1: After reset, FIFO control reads 0, the interrupt enable word reads 0, FIFO status reads 0x80 (eight free transmit slots, no receive words), and irq_o is low.
- R2: Words written to index 4 appear on tx_data_o in first-in first-out order. tx_valid_o is high while the transmit FIFO holds a word, and each tx_pop_i cycle advances to the next word.
- R3: Words pushed with rx_push_i are returned in arrival order by reads of index 4+1 (receive data), and each such read removes one word.
- R4: FIFO status bits 7:4 give the free transmit slots and bits 3:0 give the stored receive words; both saturate at 15.
- R5: Writing 1 to FIFO control bit 1 empties the transmit FIFO, and bit 0 does the same for the receive FIFO. A bit set this way reads back 1 on a read issued in the very next cycle. After that the bit reads 0 and the FIFO is empty.
- R6: FIFO control bits 7:5 hold the transmit trigger and bits 4:2 the receive trigger. Status bit 1 is high while free transmit slots exceed the transmit trigger. Status bit 0 is high while stored receive words exceed the receive trigger. Writes to these two bits have no effect.
- R7: Status bits 7 (packet done), 6 (all packets done), 3 (no acknowledge) and 2 (arbitration lost) are set by their input pulses and stay set.
- R8: Status bit 5 is set by a transmit data write while the transmit FIFO is full, and the word is dropped. Status bit 4 is set by a receive data read while the receive FIFO is empty, and that read returns 0. The evt_tx_ovf_i and evt_rx_unf_i pulses also set these bits.
- R9: Writing 1 to a sticky status bit clears it, and writing 0 leaves it unchanged. A write of 0xFF clears all sticky bits. An event pulse arriving in the same cycle as the clear wins, and the bit stays set.
- R10: irq_o is high exactly when some status bit and its enable bit were both 1 on the previous clock. It therefore rises two clocks after an event pulse is driven when the bit is already enabled.
- R11: tx_pop_i on an empty transmit FIFO and rx_push_i on a full receive FIFO are ignored; occupancy is unchanged and the pushed word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | AW (3) | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| tx_pop_i | input | 1 | Engine takes the transmit head word |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_data_o | output | 32 | Transmit head word |
| rx_push_i | input | 1 | Engine stores a received word |
| rx_data_i | input | 32 | Received word |
| evt_pkt_done_i | input | 1 | Packet complete pulse |
| evt_all_done_i | input | 1 | All packets complete pulse |
| evt_nak_i | input | 1 | No acknowledge pulse |
| evt_arb_lost_i | input | 1 | Arbitration lost pulse |
| evt_tx_ovf_i | input | 1 | Engine-side transmit overflow pulse |
| evt_rx_unf_i | input | 1 | Engine-side receive underflow pulse |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A corrupted FIFO pointer or count appears within one register read. It shows up as a wrong slot count in FIFO status, a wrong head word on tx_data_o, or a data-request bit on the wrong side of its trigger. A flush flag that sticks keeps reading 1 on the read after the flush, and the FIFO keeps emptying. A sticky bit that fails to latch or to clear shows up on the next status read. An enable or combine fault shows up on irq_o, which is checked in the exact cycle it must change, two clocks after the pulse.

// File: rtl/i2c_fic_pkg.sv
`timescale 1ns/1ps
package i2c_fic_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned NEV   = 8;
  localparam int unsigned TRG_W = 3;
  localparam int unsigned LIVE_N = 2;

  // register word indices
  localparam logic [2:0] RA_FIFO_CTRL = 3'd0;
  localparam logic [2:0] RA_FIFO_STAT = 3'd1;
  localparam logic [2:0] RA_INT_MASK  = 3'd2;
  localparam logic [2:0] RA_INT_STAT  = 3'd3;
  localparam logic [2:0] RA_TX_DATA   = 3'd4;
  localparam logic [2:0] RA_RX_DATA   = 3'd5;

  // status bit positions
  localparam int unsigned EV_PKT   = 7;
  localparam int unsigned EV_ALL   = 6;
  localparam int unsigned EV_TXOVF = 5;
  localparam int unsigned EV_RXUNF = 4;
  localparam int unsigned EV_NAK   = 3;
  localparam int unsigned EV_ARB   = 2;
  localparam int unsigned RQ_TX    = 1;
  localparam int unsigned RQ_RX    = 0;

  // fifo control bit positions
  localparam int unsigned FC_RXFL  = 0;
  localparam int unsigned FC_TXFL  = 1;
  localparam int unsigned FC_RXTRG = 2;
  localparam int unsigned FC_TXTRG = 5;

  function automatic logic [3:0] sat_nib(input logic [31:0] v);
    return (v > 32'd15) ? 4'hF : v[3:0];
  endfunction
endpackage

// File: rtl/word_fifo.sv
`timescale 1ns/1ps
module word_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fic_intc.sv
`timescale 1ns/1ps
module fic_intc #(
  parameter int unsigned NEV    = 8,
  parameter int unsigned LIVE_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              st_we_i,
  input  logic [NEV-1:0]    wdata_i,
  input  logic [NEV-1:0]    set_i,
  input  logic [LIVE_N-1:0] live_i,
  output logic [NEV-1:0]    st_o,
  output logic [NEV-1:0]    mask_o,
  output logic              irq_o
);
  logic [NEV-1:0] mask_q;
  logic           irq_q;
  logic           unused_w;

  assign unused_w = ^{set_i[LIVE_N-1:0]};

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    if (i < LIVE_N) begin : g_live
      assign st_o[i] = live_i[i];
    end else begin : g_sticky
      logic st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= 1'b0;
        else         st_q <= set_i[i] | (st_q & ~(st_we_i & wdata_i[i]));
      end
      assign st_o[i] = st_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      irq_q <= |(st_o & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/i2c_fifo_intc.sv
`timescale 1ns/1ps
module i2c_fifo_intc
  import i2c_fic_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             tx_pop_i,
  output logic             tx_valid_o,
  output logic [BUS_W-1:0] tx_data_o,
  input  logic             rx_push_i,
  input  logic [BUS_W-1:0] rx_data_i,
  input  logic             evt_pkt_done_i,
  input  logic             evt_all_done_i,
  input  logic             evt_nak_i,
  input  logic             evt_arb_lost_i,
  input  logic             evt_tx_ovf_i,
  input  logic             evt_rx_unf_i,
  output logic             irq_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [2:0]       ra;
  logic             wr, rd;
  logic [TRG_W-1:0] tx_trg_q, rx_trg_q;
  logic             tx_fl_q, rx_fl_q;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full_unused, rx_empty;
  logic [BUS_W-1:0] rx_head;
  logic [31:0]      tx_free;
  logic             tx_req, rx_req, tx_ovf, rx_unf;
  logic [NEV-1:0]   int_st, int_mask, ev_set;
  logic [BUS_W-1:0] rd_mux, rdata_q;

  assign ra = 3'(addr_i);
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  // fifo control; flush flags live for exactly one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_trg_q <= '0;
      rx_trg_q <= '0;
      tx_fl_q  <= 1'b0;
      rx_fl_q  <= 1'b0;
    end else if (wr && ra == RA_FIFO_CTRL) begin
      tx_trg_q <= wdata_i[FC_TXTRG +: TRG_W];
      rx_trg_q <= wdata_i[FC_RXTRG +: TRG_W];
      tx_fl_q  <= wdata_i[FC_TXFL];
      rx_fl_q  <= wdata_i[FC_RXFL];
    end else begin
      tx_fl_q  <= 1'b0;
      rx_fl_q  <= 1'b0;
    end
  end

  word_fifo #(.DW(BUS_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(tx_fl_q),
    .push_i (wr && ra == RA_TX_DATA),
    .data_i (wdata_i),
    .pop_i  (tx_pop_i),
    .data_o (tx_data_o),
    .cnt_o  (tx_cnt),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  word_fifo #(.DW(BUS_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(rx_fl_q),
    .push_i (rx_push_i),
    .data_i (rx_data_i),
    .pop_i  (rd && ra == RA_RX_DATA),
    .data_o (rx_head),
    .cnt_o  (rx_cnt),
    .full_o (rx_full_unused),
    .empty_o(rx_empty)
  );

  assign tx_valid_o = !tx_empty;
  assign tx_free    = DEPTH - 32'(tx_cnt);
  assign tx_req     = tx_free > 32'(tx_trg_q);
  assign rx_req     = 32'(rx_cnt) > 32'(rx_trg_q);
  assign tx_ovf     = wr && ra == RA_TX_DATA && tx_full;
  assign rx_unf     = rd && ra == RA_RX_DATA && rx_empty;

  always_comb begin
    ev_set           = '0;
    ev_set[EV_PKT]   = evt_pkt_done_i;
    ev_set[EV_ALL]   = evt_all_done_i;
    ev_set[EV_TXOVF] = evt_tx_ovf_i | tx_ovf;
    ev_set[EV_RXUNF] = evt_rx_unf_i | rx_unf;
    ev_set[EV_NAK]   = evt_nak_i;
    ev_set[EV_ARB]   = evt_arb_lost_i;
  end

  fic_intc #(.NEV(NEV), .LIVE_N(LIVE_N)) u_intc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(wr && ra == RA_INT_MASK),
    .st_we_i  (wr && ra == RA_INT_STAT),
    .wdata_i  (wdata_i[NEV-1:0]),
    .set_i    (ev_set),
    .live_i   ({tx_req, rx_req}),
    .st_o     (int_st),
    .mask_o   (int_mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (ra)
      RA_FIFO_CTRL: begin
        rd_mux[FC_TXTRG +: TRG_W] = tx_trg_q;
        rd_mux[FC_RXTRG +: TRG_W] = rx_trg_q;
        rd_mux[FC_TXFL]           = tx_fl_q;
        rd_mux[FC_RXFL]           = rx_fl_q;
      end
      RA_FIFO_STAT: rd_mux[7:0] = {sat_nib(tx_free), sat_nib(32'(rx_cnt))};
      RA_INT_MASK:  rd_mux[NEV-1:0] = int_mask;
      RA_INT_STAT:  rd_mux[NEV-1:0] = int_st;
      RA_RX_DATA:   rd_mux = rx_empty ? '0 : rx_head;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/i2c_fifo_intc_chk.sv
`timescale 1ns/1ps
module i2c_fifo_intc_chk
  import i2c_fic_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [BUS_W-1:0] wdata_i,
  input logic             evt_pkt_done_i,
  input logic             evt_nak_i,
  input logic             irq_o,
  input logic [NEV-1:0]   int_st,
  input logic [NEV-1:0]   int_mask,
  input logic [CW-1:0]    tx_cnt,
  input logic [CW-1:0]    rx_cnt,
  input logic             tx_fl_q
);
  logic ctrl_wr, st_wr, rx_rd;
  assign ctrl_wr = req_i && we_i && 3'(addr_i) == RA_FIFO_CTRL;
  assign st_wr   = req_i && we_i && 3'(addr_i) == RA_INT_STAT;
  assign rx_rd   = req_i && !we_i && 3'(addr_i) == RA_RX_DATA;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  p_flush_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fl_q && !ctrl_wr) |=> !tx_fl_q);

  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fl_q |=> (tx_cnt == '0));

  p_nak_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_nak_i |=> int_st[EV_NAK]);

  p_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && rx_cnt == '0) |=> int_st[EV_RXUNF]);

  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && wdata_i[EV_PKT] && !evt_pkt_done_i) |=> !int_st[EV_PKT]);

  p_masked_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mask == '0) |=> !irq_o);
endmodule

bind i2c_fifo_intc i2c_fifo_intc_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .evt_pkt_done_i(evt_pkt_done_i),
  .evt_nak_i     (evt_nak_i),
  .irq_o         (irq_o),
  .int_st        (int_st),
  .int_mask      (int_mask),
  .tx_cnt        (tx_cnt),
  .rx_cnt        (rx_cnt),
  .tx_fl_q       (tx_fl_q)
);

// File: tb/sim_i2c_fifo_intc.sv
`timescale 1ns/1ps
module sim_i2c_fifo_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_pop = 1'b0, tx_valid;
  logic [31:0] tx_data;
  logic        rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic        e_pkt = 0, e_all = 0, e_nak = 0, e_arb = 0, e_ovf = 0, e_unf = 0;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  i2c_fifo_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_pop_i(tx_pop), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .evt_pkt_done_i(e_pkt), .evt_all_done_i(e_all), .evt_nak_i(e_nak),
    .evt_arb_lost_i(e_arb), .evt_tx_ovf_i(e_ovf), .evt_rx_unf_i(e_unf),
    .irq_o(irq)
  );

  // {is_read, addr, data}; for reads data is the expected value
  localparam int NT = 18;
  localparam logic [35:0] TBL [NT] = '{
    {1'b1, 3'd0, 32'h0000_0000},  // R1 ctrl
    {1'b1, 3'd1, 32'h0000_0080},  // R1 R4 status
    {1'b1, 3'd2, 32'h0000_0000},  // R1 mask
    {1'b1, 3'd3, 32'h0000_0002},  // R6 free 8 > 0
    {1'b0, 3'd4, 32'h1111_1111},
    {1'b0, 3'd4, 32'h2222_2222},
    {1'b0, 3'd4, 32'h3333_3333},
    {1'b1, 3'd1, 32'h0000_0050},  // R4 five free
    {1'b0, 3'd0, 32'h0000_00A0},  // tx trigger 5
    {1'b1, 3'd3, 32'h0000_0000},  // R6 5 not > 5
    {1'b0, 3'd0, 32'h0000_0080},  // tx trigger 4
    {1'b1, 3'd3, 32'h0000_0002},  // R6 5 > 4
    {1'b0, 3'd3, 32'h0000_0003},
    {1'b1, 3'd3, 32'h0000_0002},  // R6 live bits ignore writes
    {1'b0, 3'd0, 32'h0000_0082},  // tx flush
    {1'b1, 3'd0, 32'h0000_0082},  // R5 flag visible next cycle
    {1'b1, 3'd0, 32'h0000_0080},  // R5 flag cleared
    {1'b1, 3'd1, 32'h0000_0080}   // R5 fifo empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    d = rdata; req = 0;
  endtask

  task automatic push(input logic [31:0] d);
    rx_push = 1; rx_data = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic pop();
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq at reset", {31'b0, irq}, 32'h0);
    rst_n = 1;
    idle();

    for (int i = 0; i < NT; i++) begin
      if (TBL[i][35]) begin
        rd(TBL[i][34:32], v);
        check($sformatf("table[%0d]", i), v, TBL[i][31:0]);
      end else begin
        wr(TBL[i][34:32], TBL[i][31:0]);
      end
    end

    // R2 order and pop
    wr(3'd4, 32'hA0); wr(3'd4, 32'hA1); wr(3'd4, 32'hA2);
    for (int i = 0; i < 3; i++) begin
      check("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
      check("R2 tx order", tx_data, 32'hA0 + i);
      pop();
    end
    check("R2 tx drained", {31'b0, tx_valid}, 32'h0);
    pop();  // R11 pop on empty
    rd(3'd1, v); check("R11 pop empty", v, 32'h80);

    // R8 overflow
    for (int i = 0; i < 8; i++) wr(3'd4, 32'h100 + i);
    rd(3'd3, v); check("R8 no ovf yet", v & 32'h20, 32'h0);
    wr(3'd4, 32'hDEAD);
    rd(3'd3, v); check("R8 ovf set", v & 32'h20, 32'h20);
    rd(3'd1, v); check("R4 full status", v, 32'h00);
    for (int i = 0; i < 8; i++) begin
      check("R8 ovf word dropped", tx_data, 32'h100 + i);
      pop();
    end
    check("R8 nothing after", {31'b0, tx_valid}, 32'h0);

    // R9 write-one-to-clear
    wr(3'd3, 32'h10);
    rd(3'd3, v); check("R9 zero keeps", v & 32'h20, 32'h20);
    wr(3'd3, 32'h20);
    rd(3'd3, v); check("R9 one clears", v & 32'h20, 32'h0);

    // R3 receive path
    push(32'hB0); push(32'hB1);
    rd(3'd1, v); check("R4 rx count", v, 32'h82);
    rd(3'd3, v); check("R6 rx req 2>0", v & 32'h1, 32'h1);
    wr(3'd0, 32'h88);
    rd(3'd3, v); check("R6 rx req 2>2", v & 32'h1, 32'h0);
    rd(3'd5, v); check("R3 rx first", v, 32'hB0);
    rd(3'd5, v); check("R3 rx second", v, 32'hB1);
    rd(3'd3, v); check("R8 no unf yet", v & 32'h10, 32'h0);
    rd(3'd5, v); check("R8 unf returns 0", v, 32'h0);
    rd(3'd3, v); check("R8 unf set", v & 32'h10, 32'h10);

    // R11 push on full
    for (int i = 0; i < 9; i++) push(32'hC0 + i);
    rd(3'd1, v); check("R11 rx full count", v, 32'h88);
    for (int i = 0; i < 8; i++) begin
      rd(3'd5, v); check("R3 rx order", v, 32'hC0 + i);
    end
    rd(3'd1, v); check("R11 ninth dropped", v, 32'h80);

    // R5 rx flush
    push(32'hD0); push(32'hD1);
    wr(3'd0, 32'h89);
    rd(3'd0, v); check("R5 rx flag", v, 32'h89);
    rd(3'd1, v); check("R5 rx empty", v, 32'h80);

    // R7 events, R10 irq
    wr(3'd3, 32'hFF);
    rd(3'd3, v); check("R9 all cleared", v & 32'hFC, 32'h0);
    e_nak = 1; idle(); e_nak = 0;
    rd(3'd3, v); check("R7 nak", v & 32'hFC, 32'h08);
    check("R10 masked off", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h08);
    idle();
    check("R10 irq enabled", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h08);
    idle();
    check("R10 irq drops", {31'b0, irq}, 32'h0);
    e_pkt = 1; e_all = 1; e_arb = 1; idle(); e_pkt = 0; e_all = 0; e_arb = 0;
    rd(3'd3, v); check("R7 pkt all arb", v & 32'hFC, 32'hC4);
    wr(3'd3, 32'hFF);
    wr(3'd2, 32'h80);
    e_pkt = 1; idle(); e_pkt = 0;
    check("R10 not yet", {31'b0, irq}, 32'h0);
    idle();
    check("R10 two clocks", {31'b0, irq}, 32'h1);

    // R9 set wins
    wr(3'd3, 32'hFF);
    e_arb = 1; wr(3'd3, 32'h04); e_arb = 0;
    rd(3'd3, v); check("R9 set wins", v & 32'h04, 32'h04);

    // R8 engine pulses
    wr(3'd3, 32'hFF);
    e_ovf = 1; e_unf = 1; idle(); e_ovf = 0; e_unf = 0;
    rd(3'd3, v); check("R8 engine pulses", v & 32'h30, 32'h30);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule